// File: doc/BRIEF.md
# Peripheral Bus Handshake Slave

This block connects an 8-bit register file to a host processor bus that uses a two-step handshake. When the processor presents an address, the block compares the upper address field with a fixed decode value. It also checks the address strobe, the lower data strobe and a peripheral-select line. If all of them match, the block answers with a peripheral-valid acknowledge. The processor then lowers its memory-valid line in step with its slow E clock. Data moves only while memory-valid is low.

Everything runs on one fast system clock with a synchronous active-high reset. The slow E clock is an ordinary sampled input, and the block finds its falling edge internally. Writes commit on that falling edge. Read data is driven for as long as the memory-valid window lasts and is parked at zero otherwise. Three low address bits pick one of eight registers.

Top module: `spb_host_slave`

## Requirements
- R1: After reset, `vpa_n` is 1, `d_oe` is 0, `d_out` is 0, and all eight registers read back as 0.
- R2: A full match pulls `vpa_n` low one clock later. A full match means `addr_hi` equals the decode value (default 5'h13) and `as_n`, `lds_n` and `psel_n` are all 0.
- R3: A wrong `addr_hi`, a high `lds_n` or a high `psel_n` keeps `vpa_n` high. A write attempted under any of these leaves every register unchanged.
- R4: `vpa_n` returns to 1 one clock after `as_n` goes high.
- R5: A write (`rw`=0) stores `wdata` into the register chosen by `reg_sel`. It commits on the clock where the sampled `e_clk` goes from 1 to 0, provided `vpa_n` is low and `vma_n` is low at that point.
- R6: A write whose `e_clk` falling edge arrives while `vma_n` is high has no effect.
- R7: For a read (`rw`=1), `d_oe` is 1 and `d_out` holds the selected register from the clock after `vma_n` goes low with `vpa_n` low. At all other times `d_oe` is 0 and `d_out` is 0.
- R8: The eight registers selected by `reg_sel` values 0 to 7 hold independent values.
- R9: A write cycle in which `e_clk` never falls while `vma_n` is low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 5 | Upper address field compared with the decode value |
| reg_sel | input | 3 | Register index taken from the low address bits |
| as_n | input | 1 | Address strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| psel_n | input | 1 | Peripheral select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| vma_n | input | 1 | Memory-valid from the processor, active low |
| e_clk | input | 1 | Slow E clock, sampled on `clk` |
| wdata | input | 8 | Write data |
| vpa_n | output | 1 | Peripheral-valid acknowledge, active low |
| d_out | output | 8 | Read data, 0 when not driven |
| d_oe | output | 1 | Read-data output enable |

## Verification
Writes are tried with a different byte in each of the eight registers, and each register is then read back. This separates a decoder that aliases indices from one that keeps them apart. Three more sets of write attempts each break one condition:
- one of the three match terms (address, lower strobe, select) is wrong;
- the E falling edge arrives while memory-valid is high;
- E never falls inside the window.

A later read-back then shows whether the block wrongly merged that condition into its write enable. Reads before memory-valid and after release confirm that data appears only inside the window.

// File: rtl/spb_pkg.sv
package spb_pkg;

    localparam int ADDR_HI_W = 5;
    localparam int SEL_W     = 3;
    localparam int DATA_W    = 8;
    localparam int NREGS     = 1 << SEL_W;

    typedef logic [DATA_W-1:0] byte_t;

    // Bus request as seen on the pins
    typedef struct packed {
        logic [ADDR_HI_W-1:0] addr_hi;
        logic [SEL_W-1:0]     sel;
        logic                 as_n;
        logic                 lds_n;
        logic                 psel_n;
        logic                 rw;
        logic                 vma_n;
    } bus_req_t;

    // Register-file access decided for this cycle
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [SEL_W-1:0] idx;
    } access_t;

    function automatic logic addr_hit(input bus_req_t r,
                                      input logic [ADDR_HI_W-1:0] dec);
        return (r.addr_hi == dec) && !r.as_n && !r.lds_n && !r.psel_n;
    endfunction

endpackage

// File: rtl/spb_addr_decode.sv
module spb_addr_decode
    import spb_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] DECODE_VAL = 5'h13
) (
    input  bus_req_t req,
    output logic     hit
);
    always_comb hit = addr_hit(req, DECODE_VAL);
endmodule

// File: rtl/spb_eclk_edge.sv
module spb_eclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic e_in,
    output logic e_fall
);
    logic e_q;

    always_ff @(posedge clk) begin
        if (rst) e_q <= 1'b0;
        else     e_q <= e_in;
    end

    always_comb e_fall = e_q && !e_in;
endmodule

// File: rtl/spb_regfile.sv
module spb_regfile
    import spb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [SW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << SW;

    logic [DW-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr && idx == SW'(i))
                regs[i] <= wdata;
        end
    end

    always_comb rdata = regs[idx];
endmodule

// File: rtl/spb_host_slave.sv
module spb_host_slave
    import spb_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] DECODE_VAL = 5'h13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic                 as_n,
    input  logic                 lds_n,
    input  logic                 psel_n,
    input  logic                 rw,
    input  logic                 vma_n,
    input  logic                 e_clk,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 vpa_n,
    output logic [DATA_W-1:0]    d_out,
    output logic                 d_oe
);
    bus_req_t req;
    access_t  acc;
    logic     hit;
    logic     e_fall;
    byte_t    rd_val;

    always_comb begin
        req.addr_hi = addr_hi;
        req.sel     = reg_sel;
        req.as_n    = as_n;
        req.lds_n   = lds_n;
        req.psel_n  = psel_n;
        req.rw      = rw;
        req.vma_n   = vma_n;
    end

    spb_addr_decode #(.DECODE_VAL(DECODE_VAL)) u_dec (
        .req (req),
        .hit (hit)
    );

    spb_eclk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .e_in   (e_clk),
        .e_fall (e_fall)
    );

    // Transfer window: acknowledged, still addressed, memory-valid low
    always_comb begin
        acc.idx = req.sel;
        acc.wr  = hit && !vpa_n && !req.vma_n && !req.rw && e_fall;
        acc.rd  = hit && !vpa_n && !req.vma_n &&  req.rw;
    end

    spb_regfile #(.DW(DATA_W), .SW(SEL_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .wr    (acc.wr),
        .idx   (acc.idx),
        .wdata (wdata),
        .rdata (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpa_n <= 1'b1;
            d_oe  <= 1'b0;
            d_out <= '0;
        end else begin
            vpa_n <= !hit;
            d_oe  <= acc.rd;
            d_out <= acc.rd ? rd_val : '0;
        end
    end
endmodule

// File: rtl/spb_host_slave_chk.sv
module spb_host_slave_chk
    import spb_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] DECODE_VAL = 5'h13
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_HI_W-1:0] addr_hi,
    input logic                 as_n,
    input logic                 lds_n,
    input logic                 psel_n,
    input logic                 rw,
    input logic                 vma_n,
    input logic                 vpa_n,
    input logic [DATA_W-1:0]    d_out,
    input logic                 d_oe
);
    logic full_match;
    always_comb full_match = (addr_hi == DECODE_VAL) && !as_n && !lds_n && !psel_n;

    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (vpa_n && !d_oe && d_out == '0)); // R1
    AST_VPA_ON_MATCH: assert property (@(posedge clk) disable iff (rst) full_match |=> !vpa_n); // R2
    AST_NO_VPA_WRONG_ADDR: assert property (@(posedge clk) disable iff (rst) (addr_hi != DECODE_VAL) |=> vpa_n); // R3
    AST_VPA_RELEASE: assert property (@(posedge clk) disable iff (rst) as_n |=> vpa_n); // R4
    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) d_oe |-> $past(!vpa_n && !vma_n && rw)); // R7
    AST_DOUT_PARKED: assert property (@(posedge clk) disable iff (rst) !d_oe |-> d_out == '0); // R7
endmodule

bind spb_host_slave spb_host_slave_chk #(.DECODE_VAL(DECODE_VAL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_hi (addr_hi),
    .as_n    (as_n),
    .lds_n   (lds_n),
    .psel_n  (psel_n),
    .rw      (rw),
    .vma_n   (vma_n),
    .vpa_n   (vpa_n),
    .d_out   (d_out),
    .d_oe    (d_oe)
);

// File: tb/spb_host_slave_tb.sv
`timescale 1ns/1ps
module spb_host_slave_tb;
    localparam logic [4:0] DEC = 5'h13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr_hi = '0;
    logic [2:0] reg_sel = '0;
    logic       as_n = 1'b1, lds_n = 1'b1, psel_n = 1'b1;
    logic       rw = 1'b1, vma_n = 1'b1, e_clk = 1'b0;
    logic [7:0] wdata = '0;
    logic       vpa_n, d_oe;
    logic [7:0] d_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [8];
    logic [7:0] exp_q [$];
    logic       oe_prev = 1'b0;

    always #4 clk = ~clk;

    spb_host_slave #(.DECODE_VAL(DEC)) u_dut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .reg_sel(reg_sel),
        .as_n(as_n), .lds_n(lds_n), .psel_n(psel_n), .rw(rw),
        .vma_n(vma_n), .e_clk(e_clk), .wdata(wdata),
        .vpa_n(vpa_n), .d_out(d_out), .d_oe(d_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: the first cycle of each read window pops an expected byte
    always @(negedge clk) begin
        if (!rst) begin
            if (d_oe && !oe_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected d_oe", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(d_out == e, "R5/R7/R8 read data", d_out, e);
                end
            end
            oe_prev = d_oe;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [2:0] s, input logic [7:0] d,
                             input logic lds, input logic psel, input bit use_vma,
                             input bit do_fall, input string req);
        bit m;
        m = (a == DEC) && !lds && !psel;
        @(negedge clk);
        addr_hi = a; reg_sel = s; lds_n = lds; psel_n = psel;
        as_n = 1'b0; rw = 1'b0; wdata = d;
        @(negedge clk);
        check(vpa_n == !m, m ? "R2 vpa on match" : "R3 no vpa on mismatch", vpa_n, !m);
        vma_n = use_vma ? 1'b0 : 1'b1;
        e_clk = 1'b1;
        @(negedge clk);
        e_clk = do_fall ? 1'b0 : 1'b1;
        @(negedge clk);
        as_n = 1'b1; vma_n = 1'b1; e_clk = 1'b0;
        @(negedge clk);
        check(vpa_n == 1'b1, {"R4 release ", req}, vpa_n, 1);
        lds_n = 1'b1; psel_n = 1'b1; rw = 1'b1;
        if (m && use_vma && do_fall) model[s] = d;
    endtask

    task automatic bus_read(input logic [2:0] s);
        @(negedge clk);
        addr_hi = DEC; reg_sel = s; lds_n = 1'b0; psel_n = 1'b0;
        as_n = 1'b0; rw = 1'b1;
        @(negedge clk);
        check(d_oe == 1'b0 && d_out == 8'h00, "R7 no drive before vma", d_oe, 0);
        vma_n = 1'b0;
        exp_q.push_back(model[s]);
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b1; vma_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(d_oe == 1'b0 && d_out == 8'h00, "R7 parked after release", d_out, 0);
        lds_n = 1'b1; psel_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(vpa_n == 1'b1 && d_oe == 1'b0 && d_out == 8'h00, "R1 reset outputs", vpa_n, 1);
        for (int i = 0; i < 8; i++) bus_read(3'(i));   // R1 registers cleared

        bus_write(DEC, 3'd3, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
        bus_read(3'd3);

        for (int i = 0; i < 8; i++)
            bus_write(DEC, 3'(i), 8'(8'h11 * (i + 1) ^ 8'h5C), 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 8; i++) bus_read(3'(i));

        bus_write(5'h12, 3'd1, 8'hDE, 1'b0, 1'b0, 1'b1, 1'b1, "R3 addr");
        bus_write(DEC,   3'd2, 8'hAD, 1'b1, 1'b0, 1'b1, 1'b1, "R3 lds");
        bus_write(DEC,   3'd4, 8'hBE, 1'b0, 1'b1, 1'b1, 1'b1, "R3 psel");
        bus_write(DEC,   3'd5, 8'hEF, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        bus_write(DEC,   3'd6, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 8; i++) bus_read(3'(i));

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all reads observed", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule